// File: doc/BRIEF.md
# Nonvolatile Command Key Detector

This block watches the asynchronous bus strobes and address lines of a nonvolatile SRAM and recognises a fixed key of six consecutive read accesses. Five fixed prefix addresses must be read in order. The sixth read address then chooses one of three commands: copy the SRAM into the nonvolatile array (store), copy it back (recall), or turn off the automatic store on power loss. Each recognised command is reported as a single-cycle pulse to the nonvolatile cycle controller. The prefix reads are ordinary array reads as far as the rest of the chip is concerned. This block only observes them.

The strobes and the address are brought into the system clock domain by a two-stage synchroniser. An access is detected from the synchronised falling edges. A chip-enable fall starts an access, and so does an output-enable fall while chip enable is held low. Either kind is a read when write enable is high. A write-enable fall while chip enable is low is a write. Only address bits 14 to 2 take part in the compare. While the controller reports busy, no access is counted and progress through the key is cleared.

Top module: `nv_cmd_seq_detect`

## Requirements
- R1: After reset, and after any reset in the middle of a key, all three command outputs are low and key progress starts from the first address.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read at 0x8FC0 pulse `cmd_store` high for exactly one clock.
- R3: The same five-read prefix followed by a read at 0x4C63 pulses `cmd_recall` for exactly one clock.
- R4: The same five-read prefix followed by a read at 0x8B45 pulses `cmd_asdis` for exactly one clock.
- R5: Only address bits 14 down to 2 are compared. Flipping bits 18 to 15 or 1 to 0 changes nothing. Flipping bit 14 or bit 2 of the sixth address produces no command.
- R6: A write access aborts the key and no command follows. A write is a chip-enable fall with write enable low, or a write-enable fall while chip enable is low.
- R7: A read whose address differs from the next expected address aborts the key. If that read matches the first prefix address (0x4E38), progress restarts at the second step instead of returning to idle.
- R8: The level of output enable does not matter for a chip-enable-controlled read. With chip enable held low, each falling edge of output enable counts as one read.
- R9: While `ctrl_busy` is high, accesses are ignored and key progress is cleared. A key interrupted by busy produces no command.
- R10: A command pulse appears at the third rising clock edge after the strobe edge that completes the key. At most one command output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Bus address |
| ctrl_busy | input | 1 | Nonvolatile cycle in progress, system clock domain |
| cmd_store | output | 1 | One-cycle store command pulse |
| cmd_recall | output | 1 | One-cycle recall command pulse |
| cmd_asdis | output | 1 | One-cycle automatic-store-disable command pulse |

## Verification
Clean keys for each of the three commands set the positive baseline. A variant with every don't-care address bit flipped separates masked compare from full compare. Flipping bit 14 and bit 2 of the final address shows that the bits at both ends of the compared field matter. Keys broken by a write, by a stray read, by busy or by reset tell abort from hold. Keys that restart on the first prefix address, including a restart at the sixth step, tell restart-at-step-two from a return to idle. Output-enable-controlled reads and a write-enable-controlled write cover the other two strobe sources, and a cycle-counted run pins the pulse latency and width.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int KEY_LEN = 6;
    localparam int STEP_W  = $clog2(KEY_LEN);

    // prefix addresses of the unlock key, index = step number
    function automatic logic [15:0] prefix_key(input int idx);
        case (idx)
            0:       prefix_key = 16'h4E38;
            1:       prefix_key = 16'hB1C7;
            2:       prefix_key = 16'h83E0;
            3:       prefix_key = 16'h7C1F;
            4:       prefix_key = 16'h703F;
            default: prefix_key = 16'h0000;
        endcase
    endfunction

    localparam logic [15:0] FINAL_STORE  = 16'h8FC0;
    localparam logic [15:0] FINAL_RECALL = 16'h4C63;
    localparam logic [15:0] FINAL_ASDIS  = 16'h8B45;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2,
        CMD_ASDIS  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        cmd_e              cmd;
    } seq_state_t;

endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stg_d[s] = din;
            end else begin : g_next
                always_comb stg_d[s] = stg_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/nvseq_access_det.sv
module nvseq_access_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic oe_n_s,
    input  logic we_n_s,
    output logic read_evt,
    output logic write_evt
);

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    strobe_t prev_d, prev_q;

    logic ce_fall, oe_fall, we_fall, ce_held;

    always_comb begin
        prev_d      = prev_q;
        prev_d.ce_n = ce_n_s;
        prev_d.oe_n = oe_n_s;
        prev_d.we_n = we_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
        else        prev_q <= prev_d;
    end

    // chip enable low both in the previous and the current sample
    assign ce_held = !ce_n_s && !prev_q.ce_n;
    assign ce_fall = prev_q.ce_n && !ce_n_s;
    assign oe_fall = ce_held && prev_q.oe_n && !oe_n_s;
    assign we_fall = ce_held && prev_q.we_n && !we_n_s;

    assign read_evt  = (ce_fall || oe_fall) && we_n_s;
    assign write_evt = (ce_fall && !we_n_s) || we_fall;

endmodule

// File: rtl/nvseq_key_match.sv
module nvseq_key_match
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CMP_HI = 14,
    parameter int CMP_LO = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [KEY_LEN-1:0] prefix_hit,
    output logic               hit_store,
    output logic               hit_recall,
    output logic               hit_asdis
);

    localparam int CMP_W = CMP_HI - CMP_LO + 1;

    logic [CMP_W-1:0] field;
    assign field = addr[CMP_HI:CMP_LO];

    generate
        for (genvar i = 0; i < KEY_LEN - 1; i++) begin : g_prefix
            localparam logic [15:0] KEY_I = prefix_key(i);
            assign prefix_hit[i] = (field == KEY_I[CMP_HI:CMP_LO]);
        end
    endgenerate

    // the last step has no prefix key: it is decoded by the finals below
    assign prefix_hit[KEY_LEN-1] = 1'b0;

    assign hit_store  = (field == FINAL_STORE[CMP_HI:CMP_LO]);
    assign hit_recall = (field == FINAL_RECALL[CMP_HI:CMP_LO]);
    assign hit_asdis  = (field == FINAL_ASDIS[CMP_HI:CMP_LO]);

endmodule

// File: rtl/nv_cmd_seq_detect.sv
module nv_cmd_seq_detect
    import nvseq_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SYNC_STAGES = 2,
    parameter int CMP_HI      = 14,
    parameter int CMP_LO      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ctrl_busy,
    output logic              cmd_store,
    output logic              cmd_recall,
    output logic              cmd_asdis
);

    localparam int                SYNC_W    = ADDR_W + 3;
    localparam logic [SYNC_W-1:0] SYNC_RST  = {3'b111, {ADDR_W{1'b0}}};
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);
    localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);

    logic [SYNC_W-1:0]  sync_out;
    logic               ce_n_s, we_n_s, oe_n_s;
    logic [ADDR_W-1:0]  addr_s;
    logic               read_evt, write_evt;
    logic [KEY_LEN-1:0] prefix_hit;
    logic               hit_store, hit_recall, hit_asdis;
    logic [STEP_W-1:0]  step_q;

    seq_state_t cur_d, cur_q;

    nvseq_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_ce_n, bus_oe_n, bus_we_n, bus_addr}),
        .dout  (sync_out)
    );

    assign {ce_n_s, oe_n_s, we_n_s, addr_s} = sync_out;

    nvseq_access_det u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_s    (ce_n_s),
        .oe_n_s    (oe_n_s),
        .we_n_s    (we_n_s),
        .read_evt  (read_evt),
        .write_evt (write_evt)
    );

    nvseq_key_match #(
        .ADDR_W (ADDR_W),
        .CMP_HI (CMP_HI),
        .CMP_LO (CMP_LO)
    ) u_match (
        .addr       (addr_s),
        .prefix_hit (prefix_hit),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .hit_asdis  (hit_asdis)
    );

    always_comb begin
        cur_d     = cur_q;
        cur_d.cmd = CMD_NONE;
        if (ctrl_busy) begin
            cur_d.step = '0;
        end else if (write_evt) begin
            cur_d.step = '0;
        end else if (read_evt) begin
            if (cur_q.step == LAST_STEP) begin
                cur_d.step = prefix_hit[0] ? STEP_ONE : '0;
                if (hit_store) begin
                    cur_d.cmd  = CMD_STORE;
                    cur_d.step = '0;
                end else if (hit_recall) begin
                    cur_d.cmd  = CMD_RECALL;
                    cur_d.step = '0;
                end else if (hit_asdis) begin
                    cur_d.cmd  = CMD_ASDIS;
                    cur_d.step = '0;
                end
            end else if (prefix_hit[cur_q.step]) begin
                cur_d.step = cur_q.step + STEP_ONE;
            end else if (prefix_hit[0]) begin
                cur_d.step = STEP_ONE;
            end else begin
                cur_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{step: '0, cmd: CMD_NONE};
        else        cur_q <= cur_d;
    end

    assign step_q     = cur_q.step;
    assign cmd_store  = (cur_q.cmd == CMD_STORE);
    assign cmd_recall = (cur_q.cmd == CMD_RECALL);
    assign cmd_asdis  = (cur_q.cmd == CMD_ASDIS);

endmodule

// File: rtl/nvseq_checker.sv
module nvseq_checker
    import nvseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_busy,
    input logic              read_evt,
    input logic              write_evt,
    input logic [STEP_W-1:0] step_q,
    input logic              cmd_store,
    input logic              cmd_recall,
    input logic              cmd_asdis
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

    logic cmd_any;
    assign cmd_any = cmd_store || cmd_recall || cmd_asdis;

    a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_store, cmd_recall, cmd_asdis}));

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |=> !cmd_any);

    a_r2_cmd_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |-> ($past(step_q) == LAST_STEP && $past(read_evt)));

    a_r9_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_busy |=> (step_q == '0 && !cmd_any));

    a_r6_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        write_evt |=> (step_q == '0 && !cmd_any));

    a_r7_hold_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_evt && !write_evt && !ctrl_busy) |=> ($stable(step_q) && !cmd_any));

    a_r7_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= LAST_STEP);

endmodule

bind nv_cmd_seq_detect nvseq_checker u_nvseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_busy  (ctrl_busy),
    .read_evt   (read_evt),
    .write_evt  (write_evt),
    .step_q     (step_q),
    .cmd_store  (cmd_store),
    .cmd_recall (cmd_recall),
    .cmd_asdis  (cmd_asdis)
);

// File: tb/nv_cmd_seq_detect_bench.sv
module nv_cmd_seq_detect_bench;

    localparam int AW = 19;
    localparam logic [AW-1:0] DC = 19'h78003;   // don't-care address bits

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic [2:0]    exp;   // [0] store, [1] recall, [2] auto-store disable
    } vec_t;

    localparam int NV = 63;
    localparam vec_t VECS [NV] = '{
        // R2 clean store key
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000},
        '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000}, '{19'h08FC0, 1'b0, 3'b001},
        // R3 recall key
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000},
        '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000}, '{19'h04C63, 1'b0, 3'b010},
        // R4 + R5 auto-store disable with every don't-care bit flipped
        '{19'h04E38 ^ DC, 1'b0, 3'b000}, '{19'h0B1C7 ^ DC, 1'b0, 3'b000}, '{19'h083E0 ^ DC, 1'b0, 3'b000},
        '{19'h07C1F ^ DC, 1'b0, 3'b000}, '{19'h0703F ^ DC, 1'b0, 3'b000}, '{19'h08B45 ^ DC, 1'b0, 3'b100},
        // R6 write in the middle aborts
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b1, 3'b000},
        '{19'h083E0, 1'b0, 3'b000}, '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000},
        '{19'h08FC0, 1'b0, 3'b000},
        // R7 stray read aborts
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h01234, 1'b0, 3'b000},
        '{19'h083E0, 1'b0, 3'b000}, '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000},
        '{19'h08FC0, 1'b0, 3'b000},
        // R7 first key address restarts at step two
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h04E38, 1'b0, 3'b000},
        '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000}, '{19'h07C1F, 1'b0, 3'b000},
        '{19'h0703F, 1'b0, 3'b000}, '{19'h04C63, 1'b0, 3'b010},
        // R5 bit 14 of the final address is compared
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000},
        '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000}, '{19'h0CFC0, 1'b0, 3'b000},
        // R5 bit 2 of the final address is compared
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000},
        '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000}, '{19'h08FC4, 1'b0, 3'b000},
        // R7 restart on the first key address at the sixth step
        '{19'h04E38, 1'b0, 3'b000}, '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000},
        '{19'h07C1F, 1'b0, 3'b000}, '{19'h0703F, 1'b0, 3'b000}, '{19'h04E38, 1'b0, 3'b000},
        '{19'h0B1C7, 1'b0, 3'b000}, '{19'h083E0, 1'b0, 3'b000}, '{19'h07C1F, 1'b0, 3'b000},
        '{19'h0703F, 1'b0, 3'b000}, '{19'h08B45, 1'b0, 3'b100}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_ce_n = 1'b1;
    logic          bus_we_n = 1'b1;
    logic          bus_oe_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          ctrl_busy = 1'b0;
    logic          cmd_store, cmd_recall, cmd_asdis;

    int n_tests = 0;
    int n_fail  = 0;
    int n_st = 0, n_rc = 0, n_ad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nv_cmd_seq_detect #(.ADDR_W(AW)) u_nv_cmd_seq_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ce_n   (bus_ce_n),
        .bus_we_n   (bus_we_n),
        .bus_oe_n   (bus_oe_n),
        .bus_addr   (bus_addr),
        .ctrl_busy  (ctrl_busy),
        .cmd_store  (cmd_store),
        .cmd_recall (cmd_recall),
        .cmd_asdis  (cmd_asdis)
    );

    always @(posedge clk) begin
        if (cmd_store)  n_st <= n_st + 1;
        if (cmd_recall) n_rc <= n_rc + 1;
        if (cmd_asdis)  n_ad <= n_ad + 1;
    end

    task automatic check(input string tag, input int got, input int expv);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    // one chip-enable-controlled access, output enable left high
    task automatic access(input logic [AW-1:0] a, input logic wr);
        @(negedge clk);
        bus_addr = a;
        repeat (3) @(negedge clk);
        bus_we_n = !wr;
        bus_ce_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_ce_n = 1'b1;
        bus_we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic prefix5();
        access(19'h04E38, 1'b0);
        access(19'h0B1C7, 1'b0);
        access(19'h083E0, 1'b0);
        access(19'h07C1F, 1'b0);
        access(19'h0703F, 1'b0);
    endtask

    task automatic oe_read(input logic [AW-1:0] a);
        @(negedge clk);
        bus_addr = a;
        repeat (3) @(negedge clk);
        bus_oe_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_oe_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int s0, r0, a0, lat, width;

        // R1 reset state
        repeat (4) @(negedge clk);
        check("R1 store low in reset", int'(cmd_store), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 no command after reset", int'(cmd_store | cmd_recall | cmd_asdis), 0);

        // table walk: R2/R3/R4/R5/R6/R7 (R8: output enable stays high)
        for (int v = 0; v < NV; v++) begin
            s0 = n_st; r0 = n_rc; a0 = n_ad;
            access(VECS[v].addr, VECS[v].wr);
            check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d store", v), n_st - s0, int'(VECS[v].exp[0]));
            check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d recall", v), n_rc - r0, int'(VECS[v].exp[1]));
            check($sformatf("R2/R3/R4/R5/R6/R7 vec %0d asdis", v), n_ad - a0, int'(VECS[v].exp[2]));
        end

        // R9 busy during the whole key
        s0 = n_st;
        @(negedge clk) ctrl_busy = 1'b1;
        prefix5();
        access(19'h08FC0, 1'b0);
        @(negedge clk) ctrl_busy = 1'b0;
        check("R9 busy whole key", n_st - s0, 0);

        // R9 busy pulse in the middle clears progress
        s0 = n_st;
        access(19'h04E38, 1'b0);
        access(19'h0B1C7, 1'b0);
        access(19'h083E0, 1'b0);
        @(negedge clk) ctrl_busy = 1'b1;
        repeat (10) @(negedge clk);
        ctrl_busy = 1'b0;
        access(19'h07C1F, 1'b0);
        access(19'h0703F, 1'b0);
        access(19'h08FC0, 1'b0);
        check("R9 busy mid key", n_st - s0, 0);
        prefix5();
        access(19'h08FC0, 1'b0);
        check("R9 key after busy release", n_st - s0, 1);

        // R8 output-enable-controlled reads with chip enable held low
        s0 = n_st;
        @(negedge clk) bus_addr = 19'h00000;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b0;
        repeat (5) @(negedge clk);
        oe_read(19'h04E38);
        oe_read(19'h0B1C7);
        oe_read(19'h083E0);
        oe_read(19'h07C1F);
        oe_read(19'h0703F);
        oe_read(19'h08FC0);
        bus_ce_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 output-enable reads store", n_st - s0, 1);

        // R6 write-enable-controlled write aborts
        s0 = n_st;
        @(negedge clk) bus_addr = 19'h04E38;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_we_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_we_n = 1'b1;
        bus_ce_n = 1'b1;
        repeat (5) @(negedge clk);
        access(19'h0B1C7, 1'b0);
        access(19'h083E0, 1'b0);
        access(19'h07C1F, 1'b0);
        access(19'h0703F, 1'b0);
        access(19'h08FC0, 1'b0);
        check("R6 write-enable write aborts", n_st - s0, 0);

        // R1 reset in the middle of a key
        s0 = n_st;
        access(19'h04E38, 1'b0);
        access(19'h0B1C7, 1'b0);
        access(19'h083E0, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        access(19'h07C1F, 1'b0);
        access(19'h0703F, 1'b0);
        access(19'h08FC0, 1'b0);
        check("R1 reset mid key", n_st - s0, 0);

        // R10 latency and width of the recall pulse
        prefix5();
        @(negedge clk) bus_addr = 19'h04C63;
        repeat (3) @(negedge clk);
        bus_ce_n = 1'b0;
        lat = 0;
        width = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (cmd_recall) begin
                width++;
                if (lat == 0) lat = k;
            end
        end
        bus_ce_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 pulse latency", lat, 3);
        check("R10 pulse width", width, 1);

        finish_run();
    end

endmodule